// File: doc/BRIEF.md
# Utilization-Driven Frequency Governor

This block decides the operating speed of a processor from how busy it has been. It counts, over a sampling window of a programmable number of reference-clock cycles, how many cycles the `busy` input was high. At the end of each window it compares that load against two limits. One is the up threshold, a programmable percentage. The other is a fixed lower limit of 20%. The result is an index into a table of discrete frequencies.

The policy is deliberately lopsided. Heavy load sends the speed straight to the top entry of the table. Light load lowers the speed by about one fifth at a time. Load between the two limits leaves the speed alone. A one-cycle strobe marks every window whose decision actually moves the index, so that downstream clock and voltage logic is only disturbed when there is a real change.

The block also reports the length, in cycles of the newly chosen frequency, of the window that starts next. This lets a cycle-counting consumer running at that frequency measure the same wall-clock interval.

Top module: `util_governor`

## Requirements
- R1: After reset, `freq_idx` is N_FREQ-1 (the top entry), `chg_stb` is 0, and `next_cycles` is PERIOD_MIN times the top frequency multiple.
- R2: The first window after reset lasts PERIOD_MIN cycles. Each later window lasts the value of `period_cfg`, limited to the range PERIOD_MIN..PERIOD_MAX, as sampled on the last cycle of the window before it. `freq_idx` changes only on the last cycle of a window.
- R3: If the busy count B of a window of length L satisfies B*100 > `up_thr`*L, the new index is N_FREQ-1.
- R4: If B*100 < 20*L and R3 does not apply, the new index is the highest j with 10*f(j) <= 8*f(cur), or 0 if no entry qualifies. Entry i has frequency multiple f(i) = F_BASE + i*F_STEP; with the defaults these are 2, 4, ..., 16.
- R5: If neither R3 nor R4 applies, the index is held. This includes B*100 equal to `up_thr`*L, and B*100 equal to 20*L.
- R6: `chg_stb` is high for exactly the one cycle after a window end whose decision differs from the previous index, and is low at all other times.
- R7: At every window end, `next_cycles` becomes the length of the coming window times f(new index), and it is stable between window ends.
- R8: When both the R3 and R4 conditions hold, which can happen only when `up_thr` is below 20, R3 wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| busy | input | 1 | High in each cycle the processor did useful work |
| period_cfg | input | PER_W | Requested window length in reference cycles |
| up_thr | input | THR_W | Up threshold in percent |
| freq_idx | output | log2(N_FREQ) | Current frequency table index |
| chg_stb | output | 1 | One-cycle pulse when `freq_idx` has just changed |
| next_cycles | output | PER_W+MULT_W | Length of the coming window in cycles of the chosen frequency |

## Verification
Two events can fall on the same clock edge. The first is the window end, which reloads the window length from `period_cfg`. The second is the speed decision, which raises the strobe and rescales `next_cycles` by the new table entry. The bench moves `period_cfg` to an out-of-range value in the same window that forces a change, then expects the new index, the strobe and the rescaled clamped length all in the cycle after that edge. It also sets `up_thr` below 20% and gives a load lying between the two limits, so that the raise and lower conditions are both true at once. In that case it requires the jump to the top entry.

// File: rtl/ugov_pkg.sv
package ugov_pkg;

   typedef enum logic [1:0] {
      GOV_HOLD = 2'd0,
      GOV_UP   = 2'd1,
      GOV_DOWN = 2'd2
   } gov_act_e;

   // Frequency multiple of table entry idx (entries rise with idx)
   function automatic int unsigned freq_mult(int unsigned base, int unsigned step,
                                             int unsigned idx);
      return base + idx * step;
   endfunction

   // Highest entry at or below 80% of entry cur, floor at entry 0
   function automatic int unsigned down_idx(int unsigned base, int unsigned step,
                                            int unsigned n, int unsigned cur);
      int unsigned r;
      r = 0;
      for (int unsigned j = 0; j < n; j++) begin
         if (10 * freq_mult(base, step, j) <= 8 * freq_mult(base, step, cur))
            r = j;
      end
      return r;
   endfunction

endpackage

// File: rtl/ugov_window.sv
module ugov_window #(
   parameter int PER_W      = 10,
   parameter int PERIOD_MIN = 4,
   parameter int PERIOD_MAX = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             busy,
   input  logic [PER_W-1:0] period_cfg,
   output logic             win_end,
   output logic [PER_W-1:0] busy_total,
   output logic [PER_W-1:0] win_len,
   output logic [PER_W-1:0] next_len
);
   localparam logic [PER_W-1:0] MIN_V = PER_W'(PERIOD_MIN);
   localparam logic [PER_W-1:0] MAX_V = PER_W'(PERIOD_MAX);

   logic [PER_W-1:0] cnt_q;
   logic [PER_W-1:0] bcnt_q;
   logic [PER_W-1:0] len_q;

   always_comb begin
      if (period_cfg < MIN_V)
         next_len = MIN_V;
      else if (period_cfg > MAX_V)
         next_len = MAX_V;
      else
         next_len = period_cfg;
   end

   assign win_end    = (cnt_q == len_q - PER_W'(1));
   assign busy_total = bcnt_q + PER_W'(busy);
   assign win_len    = len_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         bcnt_q <= '0;
         len_q  <= MIN_V;
      end else if (win_end) begin
         cnt_q  <= '0;
         bcnt_q <= '0;
         len_q  <= next_len;
      end else begin
         cnt_q  <= cnt_q + PER_W'(1);
         bcnt_q <= busy_total;
      end
   end

   // R2: window length always inside the legal range
   a_r2_len_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (len_q >= MIN_V) && (len_q <= MAX_V));

   // R2: position counter never passes the window end
   a_r2_cnt_below_len: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < len_q);

   // R2: length only reloads at a window end
   a_r2_len_reload: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> $stable(len_q));

endmodule

// File: rtl/ugov_decide.sv
module ugov_decide #(
   parameter int PER_W    = 10,
   parameter int THR_W    = 7,
   parameter int N_FREQ   = 8,
   parameter int F_BASE   = 2,
   parameter int F_STEP   = 2,
   parameter int DOWN_PCT = 20,
   localparam int IDX_W   = $clog2(N_FREQ)
) (
   input  logic [IDX_W-1:0]  cur_idx,
   input  logic [PER_W-1:0]  busy_total,
   input  logic [PER_W-1:0]  win_len,
   input  logic [THR_W-1:0]  up_thr,
   output logic [IDX_W-1:0]  tgt_idx,
   output ugov_pkg::gov_act_e act
);
   localparam int PROD_W = PER_W + THR_W + 1;

   logic [IDX_W-1:0]  down_tbl [N_FREQ];
   logic [PROD_W-1:0] busy_sc;
   logic [PROD_W-1:0] up_sc;
   logic [PROD_W-1:0] down_sc;
   logic              up_hit;
   logic              down_hit;

   for (genvar i = 0; i < N_FREQ; i++) begin : g_down
      assign down_tbl[i] = IDX_W'(ugov_pkg::down_idx(F_BASE, F_STEP, N_FREQ, i));
   end

   assign busy_sc  = PROD_W'(busy_total) * PROD_W'(100);
   assign up_sc    = PROD_W'(up_thr) * PROD_W'(win_len);
   assign down_sc  = PROD_W'(DOWN_PCT) * PROD_W'(win_len);
   assign up_hit   = busy_sc > up_sc;
   assign down_hit = busy_sc < down_sc;

   always_comb begin
      if (up_hit) begin
         act     = ugov_pkg::GOV_UP;
         tgt_idx = IDX_W'(N_FREQ - 1);
      end else if (down_hit) begin
         act     = ugov_pkg::GOV_DOWN;
         tgt_idx = down_tbl[cur_idx];
      end else begin
         act     = ugov_pkg::GOV_HOLD;
         tgt_idx = cur_idx;
      end
   end

endmodule

// File: rtl/ugov_scale.sv
module ugov_scale #(
   parameter int N_FREQ  = 8,
   parameter int F_BASE  = 2,
   parameter int F_STEP  = 2,
   parameter int PER_W   = 10,
   parameter int MULT_W  = 5,
   localparam int IDX_W  = $clog2(N_FREQ),
   localparam int NEXT_W = PER_W + MULT_W
) (
   input  logic [IDX_W-1:0]  idx,
   input  logic [PER_W-1:0]  len,
   output logic [NEXT_W-1:0] cycles
);
   logic [MULT_W-1:0] mult_tbl [N_FREQ];

   for (genvar i = 0; i < N_FREQ; i++) begin : g_mult
      assign mult_tbl[i] = MULT_W'(ugov_pkg::freq_mult(F_BASE, F_STEP, i));
   end

   assign cycles = NEXT_W'(len) * NEXT_W'(mult_tbl[idx]);

endmodule

// File: rtl/util_governor.sv
module util_governor #(
   parameter int N_FREQ     = 8,
   parameter int F_BASE     = 2,
   parameter int F_STEP     = 2,
   parameter int PER_W      = 10,
   parameter int PERIOD_MIN = 4,
   parameter int PERIOD_MAX = 1000,
   parameter int THR_W      = 7,
   parameter int DOWN_PCT   = 20,
   localparam int IDX_W     = $clog2(N_FREQ),
   localparam int FMAX      = F_BASE + (N_FREQ - 1) * F_STEP,
   localparam int MULT_W    = $clog2(FMAX + 1),
   localparam int NEXT_W    = PER_W + MULT_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              busy,
   input  logic [PER_W-1:0]  period_cfg,
   input  logic [THR_W-1:0]  up_thr,
   output logic [IDX_W-1:0]  freq_idx,
   output logic              chg_stb,
   output logic [NEXT_W-1:0] next_cycles
);
   localparam logic [IDX_W-1:0]  TOP_IDX = IDX_W'(N_FREQ - 1);
   localparam logic [NEXT_W-1:0] RST_NEXT = NEXT_W'(PERIOD_MIN * FMAX);

   if (N_FREQ < 2 || (1 << IDX_W) != N_FREQ) begin : g_bad_nfreq
      $error("N_FREQ must be a power of two of at least 2");
   end
   if (PERIOD_MIN < 2 || PERIOD_MIN > PERIOD_MAX || PERIOD_MAX >= (1 << PER_W)) begin : g_bad_period
      $error("period limits do not fit PER_W or are out of order");
   end
   if (F_BASE < 1 || F_STEP < 1) begin : g_bad_table
      $error("frequency table must rise strictly from a non-zero base");
   end

   logic              win_end;
   logic [PER_W-1:0]  busy_total;
   logic [PER_W-1:0]  win_len;
   logic [PER_W-1:0]  next_len;
   logic [IDX_W-1:0]  tgt_idx;
   ugov_pkg::gov_act_e act;
   logic [NEXT_W-1:0] scaled;

   ugov_window #(
      .PER_W(PER_W), .PERIOD_MIN(PERIOD_MIN), .PERIOD_MAX(PERIOD_MAX)
   ) u_window (
      .clk(clk), .rst_n(rst_n), .busy(busy), .period_cfg(period_cfg),
      .win_end(win_end), .busy_total(busy_total), .win_len(win_len),
      .next_len(next_len)
   );

   ugov_decide #(
      .PER_W(PER_W), .THR_W(THR_W), .N_FREQ(N_FREQ), .F_BASE(F_BASE),
      .F_STEP(F_STEP), .DOWN_PCT(DOWN_PCT)
   ) u_decide (
      .cur_idx(freq_idx), .busy_total(busy_total), .win_len(win_len),
      .up_thr(up_thr), .tgt_idx(tgt_idx), .act(act)
   );

   ugov_scale #(
      .N_FREQ(N_FREQ), .F_BASE(F_BASE), .F_STEP(F_STEP), .PER_W(PER_W),
      .MULT_W(MULT_W)
   ) u_scale (
      .idx(tgt_idx), .len(next_len), .cycles(scaled)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         freq_idx    <= TOP_IDX;
         chg_stb     <= 1'b0;
         next_cycles <= RST_NEXT;
      end else if (win_end) begin
         freq_idx    <= tgt_idx;
         chg_stb     <= (tgt_idx != freq_idx);
         next_cycles <= scaled;
      end else begin
         chg_stb     <= 1'b0;
      end
   end

   // R6: a strobe always accompanies a real index move
   a_r6_stb_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
      chg_stb |-> (freq_idx != $past(freq_idx)));

   // R6: without a strobe the index does not move
   a_r6_quiet_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !chg_stb |-> $stable(freq_idx));

   // R6: strobe lasts one cycle
   a_r6_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
      chg_stb |=> !chg_stb);

   // R3: heavy load lands on the top entry
   a_r3_up_goes_top: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && act == ugov_pkg::GOV_UP) |=> (freq_idx == TOP_IDX));

   // R4: light load never raises the index
   a_r4_down_not_higher: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && act == ugov_pkg::GOV_DOWN) |=> (freq_idx <= $past(freq_idx)));

   // R5: a hold decision leaves the index alone
   a_r5_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (win_end && act == ugov_pkg::GOV_HOLD) |=> $stable(freq_idx));

   // R7: reported length moves only after a window end
   a_r7_next_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !win_end |=> $stable(next_cycles));

endmodule

// File: tb/util_governor_test.sv
`timescale 1ns/1ps
module util_governor_test;
   localparam int N_FREQ = 8, F_BASE = 2, F_STEP = 2, PER_W = 10;
   localparam int PMIN = 4, PMAX = 1000, THR_W = 7;
   localparam int IDX_W = 3, NEXT_W = 15;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst_n;
   logic              busy;
   logic [PER_W-1:0]  period_cfg;
   logic [THR_W-1:0]  up_thr;
   logic [IDX_W-1:0]  freq_idx;
   logic              chg_stb;
   logic [NEXT_W-1:0] next_cycles;

   util_governor uut (
      .clk(clk), .rst_n(rst_n), .busy(busy), .period_cfg(period_cfg),
      .up_thr(up_thr), .freq_idx(freq_idx), .chg_stb(chg_stb),
      .next_cycles(next_cycles)
   );

   int n_chk = 0, n_fail = 0;
   int m_cnt, m_bcnt, m_len, m_idx, m_stb, m_next;
   string m_tag;

   function automatic int fq(int i);
      return F_BASE + i * F_STEP;
   endfunction

   function automatic int dn(int cur);
      int r = 0;
      for (int j = 0; j < N_FREQ; j++)
         if (10 * fq(j) <= 8 * fq(cur)) r = j;
      return r;
   endfunction

   function automatic int clampf(int v);
      if (v < PMIN) return PMIN;
      if (v > PMAX) return PMAX;
      return v;
   endfunction

   task automatic check(string tag, int act, int exp, string what);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic tick();
      int tot, tgt, nl;
      bit up, down;
      @(posedge clk);
      tot = m_bcnt + int'(busy);
      if (m_cnt == m_len - 1) begin
         up   = tot * 100 > int'(up_thr) * m_len;
         down = tot * 100 < 20 * m_len;
         if (up) begin tgt = N_FREQ - 1; m_tag = down ? "R8" : "R3"; end
         else if (down) begin tgt = dn(m_idx); m_tag = "R4"; end
         else begin tgt = m_idx; m_tag = "R5"; end
         nl     = clampf(int'(period_cfg));
         m_stb  = (tgt != m_idx);
         m_idx  = tgt;
         m_next = nl * fq(tgt);
         m_len  = nl;
         m_cnt  = 0;
         m_bcnt = 0;
      end else begin
         m_cnt++;
         m_bcnt = tot;
         m_stb  = 0;
         m_tag  = "R2";
      end
      @(negedge clk);
      check(m_tag, int'(freq_idx), m_idx, "freq_idx");
      check("R6", int'(chg_stb), m_stb, "chg_stb");
      check("R7", int'(next_cycles), m_next, "next_cycles");
   endtask

   // mode 0: busy for the first k cycles; mode 1: busy with k percent chance
   task automatic run_window(int cfg, int thr, int mode, int k);
      bit last;
      period_cfg = PER_W'(cfg);
      up_thr     = THR_W'(thr);
      do begin
         if (mode == 0) busy = (m_cnt < k);
         else busy = (($urandom % 100) < k);
         last = (m_cnt == m_len - 1);
         tick();
      end while (!last);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      #(200000 * 20);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      void'($urandom(32'd2718));
      rst_n = 1'b0; busy = 1'b0; period_cfg = '0; up_thr = 7'd80;
      repeat (3) @(negedge clk);
      // R1: reset values
      check("R1", int'(freq_idx), N_FREQ - 1, "freq_idx");
      check("R1", int'(chg_stb), 0, "chg_stb");
      check("R1", int'(next_cycles), PMIN * fq(N_FREQ - 1), "next_cycles");
      rst_n = 1'b1;
      m_cnt = 0; m_bcnt = 0; m_len = PMIN; m_idx = N_FREQ - 1;
      m_stb = 0; m_next = PMIN * fq(N_FREQ - 1); m_tag = "R1";

      // R2/R3: first window is PMIN long, full load stays on top, no strobe
      run_window(10, 80, 0, 4);
      // R4: idle windows walk down the table to the floor
      repeat (8) run_window(10, 80, 0, 0);
      // R3/R2: full load jumps to top while period below minimum is clamped
      run_window(2, 80, 0, 10);
      run_window(10, 50, 0, 0);
      // R5: exact up-threshold equality and exact 20% equality both hold
      run_window(10, 50, 0, 5);
      run_window(10, 50, 0, 2);
      run_window(10, 50, 0, 1);
      run_window(10, 50, 0, 6);
      // R8: threshold below 20% with load between the limits goes up
      run_window(10, 5, 0, 0);
      run_window(10, 5, 0, 1);
      // R2/R7: period above the maximum clamps, combined with a change
      run_window(10, 50, 0, 0);
      run_window(1023, 50, 0, 10);
      run_window(10, 50, 0, 600);
      // random windows
      for (int w = 0; w < 400; w++)
         run_window(int'($urandom % 48), int'($urandom % 101), 1,
                    int'($urandom % 101));
      summary();
      $finish;
   end

endmodule